// File: doc/BRIEF.md
# Clock-Sweep Page Frame Victim Selector

This block tracks a "recently used" flag and a "modified" flag for each entry of a table of physical page frames, and picks which frame to give up when a new page must be brought in. A rotating pointer remembers the frame chosen last time. A replace request starts a sweep at the frame after that pointer. The sweep looks at one frame per clock and wraps around the end of the table. The first frame found with a clear used flag becomes the victim. Any frame the sweep skips because its used flag was set loses that flag, so it gets a second chance on the next lap.

A request can ask for a clean-first search. In that mode a full lap first looks for a frame that is both unused and unmodified, and it clears nothing. Only if no such frame exists does an ordinary clearing sweep follow. Memory accesses are reported through a touch port that carries a frame index and a write flag. The chosen frame is returned with a one-cycle strobe. Moving the page data and updating the page tables are the job of the surrounding logic. When a frame is chosen, its modified flag is cleared, because it will receive a freshly loaded page.

The touch and request inputs are plain single-cycle pulses and do not use a ready handshake. The only back-pressure is `busy`: a request made while `busy` is high is dropped, and the requester must present it again once `busy` is low. The result strobe cannot be stalled.

Top module: `clock_victim_sel`

## Requirements
- R1: After reset all used and modified flags are 0, `busy` and `victim_valid` are low, and the pointer sits on frame FRAMES-1, so the first sweep starts at frame 0.
- R2: A `touch_valid` pulse sets the used flag of frame `touch_idx` at the next edge. If `touch_write` is also 1, it sets that frame's modified flag as well.
- R3: A `replace_req` seen while `busy` is low is accepted. `busy` is high after that edge. The sweep examines frames pointer+1, pointer+2, ... modulo FRAMES, one per cycle. If the victim is the s-th frame examined, `victim_valid` rises at the s-th edge after the accepting edge.
- R4: In an ordinary sweep, the victim is the first examined frame whose used flag is 0. Every examined frame whose used flag is 1 has that flag cleared and is passed over.
- R5: `victim_valid` is high for exactly one cycle, with `victim_idx` holding the chosen frame. `busy` is low in that same cycle. The pointer moves onto the victim, and the victim's modified flag is cleared.
- R6: When `clean_first` is 1 at acceptance, FRAMES frames are first examined for used=0 and modified=0, with no flag cleared. If none matches, an ordinary sweep (R4) follows, starting again at pointer+1.
- R7: A `replace_req` while `busy` is high is ignored: it neither starts a second search nor changes the current one.
- R8: A touch that names the frame whose used flag the sweep clears in the same cycle leaves the flag set. A write touch likewise wins over the modified-flag clear of a victim.
- R9: With every used flag at 1, an ordinary sweep ends at step FRAMES+1 on frame pointer+1. No search takes more than 2*FRAMES+1 steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| touch_valid | input | 1 | An access to frame `touch_idx` occurred this cycle |
| touch_idx | input | $clog2(FRAMES) | Frame index of the access |
| touch_write | input | 1 | The access was a write (marks the frame modified) |
| replace_req | input | 1 | Request a victim; taken only when `busy` is low |
| clean_first | input | 1 | With the request: prefer unused and unmodified frames first |
| busy | output | 1 | A search is in progress |
| victim_valid | output | 1 | One-cycle strobe: `victim_idx` is the chosen frame |
| victim_idx | output | $clog2(FRAMES) | Index of the chosen frame |

## Verification
If the victim is the s-th frame examined, `victim_valid` is due on the s-th rising edge after the edge that accepts the request. A touch shows up in the flags one edge after it is driven. The bench drives every input on the falling edge and steps a behavioural model by exactly one clock for each of those drives. It compares `busy`, `victim_valid` and `victim_idx` against that model at the next falling edge, so every output is checked in the cycle it is due. On top of that, directed scenarios count falling edges from the request to the strobe and compare the count with s+1, checking the latency for known sweeps of length 1, 4, 9, 17 and 8.

// File: rtl/clock_victim_pkg.sv
package clock_victim_pkg;

  typedef enum logic [1:0] {
    SW_IDLE  = 2'd0,
    SW_CLEAN = 2'd1,
    SW_REF   = 2'd2
  } sweep_state_e;

endpackage

// File: rtl/frame_flags.sv
module frame_flags #(
  parameter int FRAMES = 8,
  parameter int IDXW   = $clog2(FRAMES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mark_valid,
  input  logic [IDXW-1:0]   mark_idx,
  input  logic              mark_write,
  input  logic              clr_used_en,
  input  logic [IDXW-1:0]   clr_used_idx,
  input  logic              clr_mod_en,
  input  logic [IDXW-1:0]   clr_mod_idx,
  output logic [FRAMES-1:0] used_q,
  output logic [FRAMES-1:0] mod_q
);

  for (genvar g = 0; g < FRAMES; g++) begin : g_frame
    logic hit_mark;
    assign hit_mark = mark_valid && (mark_idx == IDXW'(g));

    // a touch always wins over a sweep clear (R8)
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        used_q[g] <= 1'b0;
      end else if (hit_mark) begin
        used_q[g] <= 1'b1;
      end else if (clr_used_en && (clr_used_idx == IDXW'(g))) begin
        used_q[g] <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        mod_q[g] <= 1'b0;
      end else if (hit_mark && mark_write) begin
        mod_q[g] <= 1'b1;
      end else if (clr_mod_en && (clr_mod_idx == IDXW'(g))) begin
        mod_q[g] <= 1'b0;
      end
    end
  end

  assert_touch_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mark_valid |=> used_q[$past(mark_idx)]);

  assert_write_sets_mod_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mark_valid && mark_write) |=> mod_q[$past(mark_idx)]);

endmodule

// File: rtl/sweep_ctrl.sv
module sweep_ctrl
  import clock_victim_pkg::*;
#(
  parameter int FRAMES = 8,
  parameter int IDXW   = $clog2(FRAMES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              clean_mode,
  input  logic [FRAMES-1:0] used_q,
  input  logic [FRAMES-1:0] mod_q,
  output logic              busy,
  output logic              found_valid,
  output logic [IDXW-1:0]   found_idx,
  output logic              clr_used_en,
  output logic [IDXW-1:0]   clr_used_idx,
  output logic              clr_mod_en,
  output logic [IDXW-1:0]   clr_mod_idx
);

  localparam int CW = (FRAMES > 1) ? $clog2(FRAMES) : 1;
  localparam int LW = $clog2(2 * FRAMES + 3) + 1;
  localparam logic [IDXW-1:0] LAST = IDXW'(FRAMES - 1);

  sweep_state_e    st;
  logic [IDXW-1:0] cur;
  logic [IDXW-1:0] ptr;
  logic [CW-1:0]   lap_cnt;
  logic [IDXW-1:0] cur_next;
  logic [IDXW-1:0] ptr_next;
  logic            cur_used;
  logic            cur_mod;
  logic            hit;

  assign cur_next = (cur == LAST) ? '0 : cur + 1'b1;
  assign ptr_next = (ptr == LAST) ? '0 : ptr + 1'b1;
  assign cur_used = used_q[cur];
  assign cur_mod  = mod_q[cur];

  always_comb begin
    hit = 1'b0;
    unique case (st)
      SW_CLEAN: hit = !cur_used && !cur_mod;
      SW_REF:   hit = !cur_used;
      default:  hit = 1'b0;
    endcase
  end

  assign busy         = (st != SW_IDLE);
  assign clr_used_en  = (st == SW_REF) && cur_used;
  assign clr_used_idx = cur;
  assign clr_mod_en   = hit;
  assign clr_mod_idx  = cur;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= SW_IDLE;
      cur         <= '0;
      ptr         <= LAST;
      lap_cnt     <= '0;
      found_valid <= 1'b0;
      found_idx   <= '0;
    end else begin
      found_valid <= 1'b0;
      unique case (st)
        SW_IDLE: begin
          if (start) begin
            cur     <= ptr_next;
            lap_cnt <= '0;
            st      <= clean_mode ? SW_CLEAN : SW_REF;
          end
        end
        SW_CLEAN, SW_REF: begin
          if (hit) begin
            st          <= SW_IDLE;
            ptr         <= cur;
            found_idx   <= cur;
            found_valid <= 1'b1;
          end else begin
            cur <= cur_next;
            if (st == SW_CLEAN) begin
              if (lap_cnt == CW'(FRAMES - 1)) begin
                st <= SW_REF;
              end else begin
                lap_cnt <= lap_cnt + 1'b1;
              end
            end
          end
        end
        default: st <= SW_IDLE;
      endcase
    end
  end

  // search length monitor for the step bound
  logic [LW-1:0] steps;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      steps <= '0;
    end else if (!busy) begin
      steps <= '0;
    end else begin
      steps <= steps + 1'b1;
    end
  end

  assert_step_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (steps <= LW'(2 * FRAMES + 1)));

  assert_busy_after_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  assert_strobe_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    found_valid |=> !found_valid);

  assert_strobe_ends_search_R5: assert property (@(posedge clk) disable iff (!rst_n)
    found_valid |-> (!busy && $past(busy)));

endmodule

// File: rtl/clock_victim_sel.sv
module clock_victim_sel #(
  parameter int FRAMES = 8,
  parameter int IDXW   = $clog2(FRAMES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            touch_valid,
  input  logic [IDXW-1:0] touch_idx,
  input  logic            touch_write,
  input  logic            replace_req,
  input  logic            clean_first,
  output logic            busy,
  output logic            victim_valid,
  output logic [IDXW-1:0] victim_idx
);

  logic [FRAMES-1:0] used_q;
  logic [FRAMES-1:0] mod_q;
  logic              clr_used_en;
  logic [IDXW-1:0]   clr_used_idx;
  logic              clr_mod_en;
  logic [IDXW-1:0]   clr_mod_idx;
  logic              start;

  assign start = replace_req && !busy;

  frame_flags #(.FRAMES(FRAMES), .IDXW(IDXW)) u_flags (
    .clk          (clk),
    .rst_n        (rst_n),
    .mark_valid   (touch_valid),
    .mark_idx     (touch_idx),
    .mark_write   (touch_write),
    .clr_used_en  (clr_used_en),
    .clr_used_idx (clr_used_idx),
    .clr_mod_en   (clr_mod_en),
    .clr_mod_idx  (clr_mod_idx),
    .used_q       (used_q),
    .mod_q        (mod_q)
  );

  sweep_ctrl #(.FRAMES(FRAMES), .IDXW(IDXW)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .clean_mode   (clean_first),
    .used_q       (used_q),
    .mod_q        (mod_q),
    .busy         (busy),
    .found_valid  (victim_valid),
    .found_idx    (victim_idx),
    .clr_used_en  (clr_used_en),
    .clr_used_idx (clr_used_idx),
    .clr_mod_en   (clr_mod_en),
    .clr_mod_idx  (clr_mod_idx)
  );

  // a victim's used flag is clear unless a touch landed on it in the deciding cycle
  assert_victim_unused_R4: assert property (@(posedge clk) disable iff (!rst_n)
    victim_valid |-> (!used_q[victim_idx] || $past(touch_valid && (touch_idx == victim_idx))));

endmodule

// File: tb/clock_victim_sel_tb.sv
module clock_victim_sel_tb;

  localparam int N  = 8;
  localparam int IW = $clog2(N);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          touch_valid;
  logic [IW-1:0] touch_idx;
  logic          touch_write;
  logic          replace_req;
  logic          clean_first;
  logic          busy;
  logic          victim_valid;
  logic [IW-1:0] victim_idx;

  always #10 clk = ~clk;

  clock_victim_sel #(.FRAMES(N)) u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .touch_valid  (touch_valid),
    .touch_idx    (touch_idx),
    .touch_write  (touch_write),
    .replace_req  (replace_req),
    .clean_first  (clean_first),
    .busy         (busy),
    .victim_valid (victim_valid),
    .victim_idx   (victim_idx)
  );

  int errors = 0;
  int checks = 0;

  // behavioural model
  bit m_used [N];
  bit m_mod  [N];
  int m_ptr, m_cur, m_mode, m_lap;   // m_mode: 0 idle, 1 clean lap, 2 clearing sweep
  bit m_vv;
  int m_vidx;

  bit seen;
  int last_v;
  int pulses;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < N; i++) begin
      m_used[i] = 0;
      m_mod[i]  = 0;
    end
    m_ptr = N - 1; m_cur = 0; m_mode = 0; m_lap = 0; m_vv = 0; m_vidx = 0;
  endtask

  task automatic model_step(input bit rq, input bit cf, input bit tv, input int ti, input bit tw);
    bit h;
    h = 0;
    if (m_mode == 1) h = !m_used[m_cur] && !m_mod[m_cur];
    if (m_mode == 2) h = !m_used[m_cur];
    m_vv = 0;
    if (m_mode == 0) begin
      if (rq) begin
        m_cur  = (m_ptr + 1) % N;
        m_mode = cf ? 1 : 2;
        m_lap  = 0;
      end
    end else if (h) begin
      m_ptr = m_cur; m_vv = 1; m_vidx = m_cur; m_mode = 0;
      m_mod[m_cur] = 0;
    end else begin
      if (m_mode == 2) m_used[m_cur] = 0;
      m_cur = (m_cur + 1) % N;
      if (m_mode == 1) begin
        if (m_lap == N - 1) m_mode = 2;
        else m_lap++;
      end
    end
    if (tv) begin
      m_used[ti] = 1;
      if (tw) m_mod[ti] = 1;
    end
  endtask

  // one clock: compare at the falling edge, then drive and step the model
  task automatic cycle(input bit rq, input bit cf, input bit tv, input int ti, input bit tw);
    @(negedge clk);
    chk(busy == (m_mode != 0), "R7 busy", int'(busy), int'(m_mode != 0));
    chk(victim_valid == m_vv, "R5 victim_valid", int'(victim_valid), int'(m_vv));
    if (m_vv) chk(int'(victim_idx) == m_vidx, "R4 victim_idx", int'(victim_idx), m_vidx);
    if (victim_valid) begin
      seen = 1; last_v = int'(victim_idx); pulses++;
    end
    replace_req = rq; clean_first = cf;
    touch_valid = tv; touch_idx = IW'(ti); touch_write = tw;
    model_step(rq, cf, tv, ti, tw);
  endtask

  task automatic idle();
    cycle(0, 0, 0, 0, 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    replace_req = 0; clean_first = 0; touch_valid = 0; touch_idx = '0; touch_write = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    model_reset();
  endtask

  // wait for the strobe; returns number of falling edges since the request drive
  task automatic wait_done(output int n);
    seen = 0; n = 0;
    while (!seen && n < 40) begin
      idle();
      n++;
    end
  endtask

  int n;

  initial begin
    do_reset();

    // R1: reset state
    @(negedge clk);
    chk(busy == 0 && victim_valid == 0, "R1 idle after reset", int'(busy), 0);
    // R1 R3: first sweep starts at frame 0, one step
    cycle(1, 0, 0, 0, 0);
    wait_done(n);
    chk(last_v == 0, "R1 first victim", last_v, 0);
    chk(n == 2, "R3 latency 1 step", n, 2);

    // R2 R4: touch 0..2, sweep clears them and stops at 3
    do_reset();
    for (int i = 0; i < 3; i++) cycle(0, 0, 1, i, 0);
    cycle(1, 0, 0, 0, 0);
    wait_done(n);
    chk(last_v == 3, "R2 touched frames skipped", last_v, 3);
    chk(n == 5, "R3 latency 4 steps", n, 5);
    for (int k = 0; k < 5; k++) begin
      cycle(1, 0, 0, 0, 0);
      wait_done(n);
    end
    chk(last_v == 0, "R4 passed frame was cleared", last_v, 0);

    // R9: all used flags set
    do_reset();
    for (int i = 0; i < N; i++) cycle(0, 0, 1, i, 0);
    cycle(1, 0, 0, 0, 0);
    wait_done(n);
    chk(last_v == 0, "R9 full lap victim", last_v, 0);
    chk(n == N + 2, "R9 full lap latency", n, N + 2);

    // R8: touch frame 0 in the cycle the sweep clears it
    do_reset();
    for (int i = 0; i < N; i++) cycle(0, 0, 1, i, 0);
    cycle(1, 0, 0, 0, 0);
    cycle(0, 0, 1, 0, 0);
    wait_done(n);
    chk(last_v == 1, "R8 touch wins over clear", last_v, 1);

    // R6: clean-first skips modified and used frames without clearing
    do_reset();
    cycle(0, 0, 1, 0, 1);
    cycle(0, 0, 1, 1, 1);
    cycle(0, 0, 1, 2, 0);
    cycle(1, 1, 0, 0, 0);
    wait_done(n);
    chk(last_v == 3, "R6 clean unused frame chosen", last_v, 3);
    cycle(1, 1, 0, 0, 0);
    wait_done(n);
    chk(last_v == 4, "R6 next clean frame", last_v, 4);

    // R6 R5: all modified -> fallback sweep; victim's modified flag cleared
    do_reset();
    for (int i = 0; i < N; i++) cycle(0, 0, 1, i, 1);
    cycle(1, 1, 0, 0, 0);
    wait_done(n);
    chk(last_v == 0, "R6 fallback victim", last_v, 0);
    chk(n == 2 * N + 2, "R6 fallback latency", n, 2 * N + 2);
    cycle(1, 1, 0, 0, 0);
    wait_done(n);
    chk(last_v == 0, "R5 victim left clean", last_v, 0);
    chk(n == N + 1, "R5 clean lap latency", n, N + 1);

    // R7: requests while busy are dropped
    do_reset();
    for (int i = 0; i < N; i++) cycle(0, 0, 1, i, 0);
    cycle(1, 0, 0, 0, 0);
    pulses = 0;
    for (int k = 0; k < N; k++) cycle(1, 1, 0, 0, 0);
    repeat (6) idle();
    chk(pulses == 1, "R7 single result", pulses, 1);
    chk(last_v == 0, "R7 search unchanged", last_v, 0);

    idle();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule